// File: doc/BRIEF.md
# Self-Tuning Estimator Calibration Sequencer

This block keeps a digital inductor-current estimator accurate while the converter stays in regulation. From time to time it switches on a test current sink of known size at the converter output and watches how the estimate responds. From the responses it corrects the estimator's gain and filter time constant. It first waits for the voltage loop to settle and stores the current estimate as a reference. It then turns on the sink, waits for the loop to settle again and measures the apparent step. The resistance estimate is scaled by the ratio of measured step to known step, and the gain is scaled by the inverse ratio.

A second phase tunes the filter time constant. With the sink off the loop settles again. The sink is then pulsed, and at the output-voltage valley the estimate is compared with the reference plus the known step. An estimate above the target means the filter is too fast, so the time-constant code goes up by one. An estimate below the target lowers the code by one. This repeats over successive pulses until the error falls inside a deadband or an iteration limit is reached. Every wait is bounded by a programmable timeout, and a timeout returns the block to idle with the sink released.

Top module: `cal_seq`

## Requirements
- R1: After reset, sink_en_o and coef_we_o are 0, rl_o = RL_INIT, gain_o = GAIN_INIT and tau_o = TAU_INIT.
- R2: With interval_cycles = 0 no calibration ever starts. With a nonzero value, a calibration starts after the block has spent that many cycles idle, and this recurs.
- R3: Before the sink is enabled, loop_err must stay within ±settle_band for SETTLE_CYC consecutive cycles. est_i is then stored as the reference I1 used by both phases.
- R4: With the sink on and the loop settled again, dIm = est_i − I1. Then rl_o becomes floor(rl_o·dIm/step_size) and gain_o becomes floor(gain_o·step_size/dIm), each saturated to all ones. The gain write shows as one coef_we_o pulse while sink_en_o is 0.
- R5: If dIm ≤ 0 or step_size = 0, the sink is released and rl_o, gain_o and tau_o are unchanged, with no coef_we_o pulse.
- R6: In the second phase, diff = est_i − (I1 + step_size) is taken on a valley_i cycle while the sink is on. If diff > tau_band, tau_o rises by 1. If diff < −tau_band, tau_o falls by 1. Otherwise tuning ends. Each change gives one coef_we_o pulse while sink_en_o is 0.
- R7: c1_o equals tau_o and c2_o equals 2^TW − tau_o, both TW+1 bits wide, so the coefficients sum to unity.
- R8: One calibration makes at most MAX_ITER valley comparisons and then returns to idle.
- R9: If a wait (baseline settle, step settle, rest settle or valley) lasts past timeout_cycles, the block goes idle with the sink off and no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interval_cycles | input | CW | Idle cycles between calibrations; 0 disables |
| timeout_cycles | input | CW | Limit on any wait |
| step_size | input | IW-1 | Known test step in estimate LSBs |
| settle_band | input | EW-1 | Loop error band for steady state |
| tau_band | input | IW-1 | Deadband for the valley comparison |
| est_i | input | IW | Signed current estimate |
| loop_err | input | EW | Signed voltage-loop error |
| valley_i | input | 1 | Output-voltage valley indication |
| sink_en_o | output | 1 | Test sink enable |
| coef_we_o | output | 1 | Coefficient write strobe |
| rl_o | output | RW | Resistance estimate |
| gain_o | output | GW | Estimator gain |
| tau_o | output | TW | Time-constant code |
| c1_o | output | TW+1 | Feedback coefficient |
| c2_o | output | TW+1 | Input coefficient |

## Verification
The bench models the estimator. Its apparent step scales with gain_o, and at the valley it adds an offset proportional to the gap between a hidden true time constant and tau_o.

Measured steps of twice, three quarters and ten times the known step check both directions of the gain correction and the saturation of the resistance. Zero and negative measured steps check the rejection path.

True time constants above, below and far beyond the current code separate overshoot, undershoot and the iteration limit. Loop errors held outside the band, before the step and during it, tell a baseline timeout from a step timeout.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_BASE, S_GSTEP, S_DIV_R, S_DIV_G, S_TREST, S_TSTEP
  } cal_state_e;
endpackage

// File: rtl/cal_settle.sv
// Steady-state detector: counts consecutive in-band error samples.
module cal_settle #(
  parameter int EW         = 10,
  parameter int SETTLE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic signed [EW-1:0] err,
  input  logic        [EW-2:0] band,
  output logic                 settled
);
  localparam int SCW = $clog2(SETTLE_CYC + 1);

  logic signed [EW:0] err_x, band_x;
  logic               in_band;
  logic [SCW-1:0]     cnt_q, cnt_d;

  assign err_x   = {err[EW-1], err};
  assign band_x  = {2'b00, band};
  assign in_band = (err_x <= band_x) && (err_x >= -band_x);
  assign settled = (cnt_q == SCW'(SETTLE_CYC));

  always_comb begin
    cnt_d = cnt_q;
    if (clr || !in_band)                cnt_d = '0;
    else if (cnt_q != SCW'(SETTLE_CYC)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cal_div.sv
// Serial restoring divider, one quotient bit per cycle.
module cal_div #(
  parameter int NW = 24,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CNW = $clog2(NW + 1);

  logic [DW-1:0]  rem_q, den_q, diff;
  logic [NW-1:0]  quo_q;
  logic [CNW-1:0] cnt_q;
  logic           busy_q, done_q, ge;
  logic [DW:0]    trial;

  assign trial = {rem_q, quo_q[NW-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign diff  = trial[DW-1:0] - den_q;
  assign done  = done_q;
  assign quo   = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        quo_q  <= num;
        den_q  <= den;
        rem_q  <= '0;
        cnt_q  <= CNW'(NW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        rem_q <= ge ? diff : trial[DW-1:0];
        quo_q <= {quo_q[NW-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cal_coef.sv
// First-order IIR coefficients with unity DC gain from the tau code.
module cal_coef #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] tau,
  output logic [TW:0]   c1,
  output logic [TW:0]   c2
);
  assign c1 = {1'b0, tau};
  assign c2 = {1'b1, {TW{1'b0}}} - {1'b0, tau};
endmodule

// File: rtl/cal_seq.sv
module cal_seq
  import cal_seq_pkg::*;
#(
  parameter int IW         = 12,
  parameter int EW         = 10,
  parameter int RW         = 12,
  parameter int GW         = 12,
  parameter int TW         = 8,
  parameter int CW         = 16,
  parameter int SETTLE_CYC = 4,
  parameter int MAX_ITER   = 8,
  parameter int RL_INIT    = 512,
  parameter int GAIN_INIT  = 512,
  parameter int TAU_INIT   = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        interval_cycles,
  input  logic [CW-1:0]        timeout_cycles,
  input  logic [IW-2:0]        step_size,
  input  logic [EW-2:0]        settle_band,
  input  logic [IW-2:0]        tau_band,
  input  logic signed [IW-1:0] est_i,
  input  logic signed [EW-1:0] loop_err,
  input  logic                 valley_i,
  output logic                 sink_en_o,
  output logic                 coef_we_o,
  output logic [RW-1:0]        rl_o,
  output logic [GW-1:0]        gain_o,
  output logic [TW-1:0]        tau_o,
  output logic [TW:0]          c1_o,
  output logic [TW:0]          c2_o
);
  localparam int MW  = (RW > GW) ? RW : GW;
  localparam int NW  = MW + IW;
  localparam int ITW = $clog2(MAX_ITER + 1);

  cal_state_e         state_q, state_d;
  logic [CW-1:0]      wait_cnt_q, wait_cnt_d;
  logic signed [IW-1:0] i1_q;
  logic [IW-1:0]      dim_q;
  logic [RW-1:0]      rl_q, q_rl;
  logic [GW-1:0]      gain_q, q_gain;
  logic [TW-1:0]      tau_q;
  logic [ITW-1:0]     iter_q;
  logic               tau_ok_q, we_q;
  logic               state_chg, settled, timed_out, idle_go, dim_pos;
  logic               cap_i1, cap_dim, rl_upd, gain_upd, valley_cmp;
  logic               over, under, tau_inc, tau_dec;
  logic signed [IW:0]   dim_w;
  logic signed [IW+1:0] exp_w, diff_w, band_w;
  logic               div_go, div_done;
  logic [NW-1:0]      div_num, div_quo;
  logic [IW-1:0]      div_den;

  cal_settle #(.EW(EW), .SETTLE_CYC(SETTLE_CYC)) settle_i (
    .clk(clk), .rst_n(rst_n), .clr(state_chg), .err(loop_err),
    .band(settle_band), .settled(settled)
  );

  cal_div #(.NW(NW), .DW(IW)) div_i (
    .clk(clk), .rst_n(rst_n), .start(div_go), .num(div_num),
    .den(div_den), .done(div_done), .quo(div_quo)
  );

  cal_coef #(.TW(TW)) coef_i (.tau(tau_q), .c1(c1_o), .c2(c2_o));

  // Arithmetic on the captured samples
  assign dim_w     = {est_i[IW-1], est_i} - {i1_q[IW-1], i1_q};
  assign dim_pos   = !dim_w[IW] && (dim_w != '0);
  assign exp_w     = {{2{i1_q[IW-1]}}, i1_q} + {3'b000, step_size};
  assign diff_w    = {{2{est_i[IW-1]}}, est_i} - exp_w;
  assign band_w    = {3'b000, tau_band};
  assign over      = diff_w > band_w;
  assign under     = diff_w < -band_w;
  assign timed_out = wait_cnt_q >= timeout_cycles;
  assign idle_go   = (interval_cycles != '0) &&
                     ({1'b0, wait_cnt_q} + 1'b1 >= {1'b0, interval_cycles});

  always_comb begin
    if (state_q == S_DIV_R) begin
      div_num = NW'(rl_q) * NW'(dim_q);
      div_den = IW'(step_size);
    end else begin
      div_num = NW'(gain_q) * NW'(step_size);
      div_den = dim_q;
    end
  end
  assign div_go = ((state_q == S_DIV_R) || (state_q == S_DIV_G)) && (wait_cnt_q == '0);
  assign q_rl   = (|div_quo[NW-1:RW]) ? {RW{1'b1}} : div_quo[RW-1:0];
  assign q_gain = (|div_quo[NW-1:GW]) ? {GW{1'b1}} : div_quo[GW-1:0];

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (idle_go) state_d = S_BASE;
      S_BASE:  if (timed_out) state_d = S_IDLE;
               else if (settled) state_d = (step_size != '0) ? S_GSTEP : S_IDLE;
      S_GSTEP: if (timed_out) state_d = S_IDLE;
               else if (settled) state_d = dim_pos ? S_DIV_R : S_IDLE;
      S_DIV_R: if (div_done) state_d = S_DIV_G;
      S_DIV_G: if (div_done) state_d = S_TREST;
      S_TREST: if (timed_out) state_d = S_IDLE;
               else if (settled)
                 state_d = (tau_ok_q || (iter_q >= ITW'(MAX_ITER))) ? S_IDLE : S_TSTEP;
      S_TSTEP: if (timed_out) state_d = S_IDLE;
               else if (valley_i) state_d = S_TREST;
      default: state_d = S_IDLE;
    endcase
  end

  assign state_chg  = state_d != state_q;
  assign wait_cnt_d = state_chg ? '0 : ((wait_cnt_q == '1) ? wait_cnt_q : wait_cnt_q + 1'b1);
  assign cap_i1     = (state_q == S_BASE)  && (state_d == S_GSTEP);
  assign cap_dim    = (state_q == S_GSTEP) && (state_d == S_DIV_R);
  assign rl_upd     = (state_q == S_DIV_R) && div_done;
  assign gain_upd   = (state_q == S_DIV_G) && div_done;
  assign valley_cmp = (state_q == S_TSTEP) && (state_d == S_TREST);
  assign tau_inc    = valley_cmp && over  && (tau_q != '1);
  assign tau_dec    = valley_cmp && under && (tau_q != '0);

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      wait_cnt_q <= '0;
      i1_q       <= '0;
      dim_q      <= '0;
      rl_q       <= RW'(RL_INIT);
      gain_q     <= GW'(GAIN_INIT);
      tau_q      <= TW'(TAU_INIT);
      iter_q     <= '0;
      tau_ok_q   <= 1'b0;
      we_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      wait_cnt_q <= wait_cnt_d;
      we_q       <= gain_upd | tau_inc | tau_dec;
      if (cap_i1)   i1_q   <= est_i;
      if (cap_dim)  dim_q  <= dim_w[IW-1:0];
      if (rl_upd)   rl_q   <= q_rl;
      if (gain_upd) gain_q <= q_gain;
      if (tau_inc)      tau_q <= tau_q + 1'b1;
      else if (tau_dec) tau_q <= tau_q - 1'b1;
      if (gain_upd) begin
        iter_q   <= '0;
        tau_ok_q <= 1'b0;
      end else if (valley_cmp) begin
        iter_q <= iter_q + 1'b1;
        if (!over && !under) tau_ok_q <= 1'b1;
      end
    end
  end

  assign sink_en_o = (state_q == S_GSTEP) || (state_q == S_TSTEP);
  assign coef_we_o = we_q;
  assign rl_o      = rl_q;
  assign gain_o    = gain_q;
  assign tau_o     = tau_q;
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk
  import cal_seq_pkg::*;
#(
  parameter int IW = 12,
  parameter int RW = 12,
  parameter int GW = 12,
  parameter int TW = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input cal_state_e    state_q,
  input logic [CW-1:0] wait_cnt_q,
  input logic [CW-1:0] timeout_cycles,
  input logic [IW-1:0] dim_q,
  input logic          sink_en_o,
  input logic          coef_we_o,
  input logic [RW-1:0] rl_o,
  input logic [GW-1:0] gain_o,
  input logic [TW-1:0] tau_o
);
  a_r4_gain_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain_o) |-> coef_we_o);

  a_r4_we_sink_off: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we_o |-> !sink_en_o);

  a_r4_rl_sink_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rl_o) |-> !sink_en_o);

  a_r5_dim_positive: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_DIV_R) || (state_q == S_DIV_G)) |-> (dim_q != '0));

  a_r6_tau_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tau_o) |-> ((tau_o == $past(tau_o) + TW'(1)) || (tau_o == $past(tau_o) - TW'(1))));

  a_r6_tau_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tau_o) |-> coef_we_o);

  a_r9_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_BASE) || (state_q == S_GSTEP) || (state_q == S_TREST) || (state_q == S_TSTEP))
      |-> (wait_cnt_q <= timeout_cycles));
endmodule

bind cal_seq cal_seq_chk #(.IW(IW), .RW(RW), .GW(GW), .TW(TW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .wait_cnt_q(wait_cnt_q),
  .timeout_cycles(timeout_cycles), .dim_q(dim_q), .sink_en_o(sink_en_o),
  .coef_we_o(coef_we_o), .rl_o(rl_o), .gain_o(gain_o), .tau_o(tau_o)
);

// File: tb/cal_seq_tb.sv
module cal_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 40;
  localparam int K    = 4;
  localparam int TO   = 60;
  localparam int MAXI = 8;

  logic               clk, rst_n;
  logic [15:0]        interval_cycles, timeout_cycles;
  logic [10:0]        step_size, tau_band;
  logic [8:0]         settle_band;
  logic signed [11:0] est_i;
  logic signed [9:0]  loop_err;
  logic               valley_i;
  logic               sink_en_o, coef_we_o;
  logic [11:0]        rl_o, gain_o;
  logic [7:0]         tau_o;
  logic [8:0]         c1_o, c2_o;

  int checks = 0, failures = 0, we_cnt = 0;
  int s_cur = 0, tau_true = 100, base = 500, est_v = 0;
  int m_rl = 512, m_gain = 512, m_tau = 100;
  logic err_big = 1'b0, err_on_sink = 1'b0;

  cal_seq dut_i (
    .clk(clk), .rst_n(rst_n), .interval_cycles(interval_cycles),
    .timeout_cycles(timeout_cycles), .step_size(step_size),
    .settle_band(settle_band), .tau_band(tau_band), .est_i(est_i),
    .loop_err(loop_err), .valley_i(valley_i), .sink_en_o(sink_en_o),
    .coef_we_o(coef_we_o), .rl_o(rl_o), .gain_o(gain_o), .tau_o(tau_o),
    .c1_o(c1_o), .c2_o(c2_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Estimator / converter model
  always_comb begin
    est_v = base + (sink_en_o ? (s_cur * int'(gain_o)) / 1024 : 0)
                 + (valley_i ? (tau_true - int'(tau_o)) * K : 0);
    est_i = 12'(est_v);
    loop_err = (err_big || (err_on_sink && sink_en_o)) ? 10'sd100 : 10'sd0;
  end

  initial begin
    int hi;
    hi = 0;
    valley_i = 1'b0;
    forever begin
      @(negedge clk);
      valley_i = 1'b0;
      if (sink_en_o && we_cnt > 0) begin
        hi++;
        if (hi == 3) valley_i = 1'b1;
      end else hi = 0;
    end
  end

  initial forever begin
    @(negedge clk);
    if (coef_we_o) we_cnt++;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_quiet(int q);
    int lo, guard;
    lo = 0;
    guard = 0;
    while (lo < q && guard < 20000) begin
      @(negedge clk);
      if (sink_en_o) lo = 0; else lo++;
      guard++;
    end
  endtask

  task automatic kick();
    int g;
    g = 0;
    interval_cycles = 16'd10;
    while (!sink_en_o && g < 400) begin @(negedge clk); g++; end
    interval_cycles = 16'd0;
    chk("R2", "calibration started", int'(sink_en_o), 1);
  endtask

  task automatic check_vals(string req);
    chk(req, "rl", int'(rl_o), m_rl);
    chk(req, "gain", int'(gain_o), m_gain);
    chk(req, "tau", int'(tau_o), m_tau);
    chk("R7", "c1", int'(c1_o), m_tau);
    chk("R7", "c2", int'(c2_o), 256 - m_tau);
  endtask

  // Full calibration with model-computed expectations (R3, R4, R5, R6, R8)
  task automatic run_cal(string req, int s, int ttrue, int b);
    int meas, m2, d, exp_we;
    s_cur = s; tau_true = ttrue; base = b; we_cnt = 0;
    exp_we = 0;
    meas = (s * m_gain) / 1024;
    if (meas > 0) begin
      m_rl = (m_rl * meas) / STEP;
      if (m_rl > 4095) m_rl = 4095;
      m_gain = (m_gain * STEP) / meas;
      if (m_gain > 4095) m_gain = 4095;
      exp_we = 1;
      m2 = (s * m_gain) / 1024;
      for (int i = 0; i < MAXI; i++) begin
        d = (m2 - STEP) + (ttrue - m_tau) * K;
        if (d > 2) begin m_tau++; exp_we++; end
        else if (d < -2) begin m_tau--; exp_we++; end
        else break;
      end
    end
    kick();
    wait_quiet(120);
    chk(req, "write pulses", we_cnt, exp_we);
    check_vals(req);
  endtask

  task automatic t_reset();
    chk("R1", "sink", int'(sink_en_o), 0);
    chk("R1", "we", int'(coef_we_o), 0);
    check_vals("R1");
  endtask

  task automatic t_disabled();
    int hi;
    hi = 0;
    interval_cycles = 16'd0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (sink_en_o) hi++; end
    chk("R2", "sink cycles with interval 0", hi, 0);
  endtask

  task automatic t_base_timeout();
    int hi;
    hi = 0;
    err_big = 1'b1; we_cnt = 0;
    interval_cycles = 16'd10;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i == 100) interval_cycles = 16'd0;
      if (sink_en_o) hi++;
    end
    err_big = 1'b0;
    chk("R3", "sink while loop unsettled", hi, 0);
    chk("R9", "writes after baseline timeout", we_cnt, 0);
    check_vals("R9");
  endtask

  task automatic t_step_timeout();
    int hi, g;
    hi = 0; g = 0;
    err_on_sink = 1'b1; we_cnt = 0; s_cur = 1205;
    kick();
    while (sink_en_o && g < 1000) begin @(negedge clk); hi++; g++; end
    err_on_sink = 1'b0;
    chk("R9", "sink high cycles ok", int'(hi >= TO && hi <= TO + 2), 1);
    wait_quiet(120);
    chk("R9", "writes after step timeout", we_cnt, 0);
    check_vals("R9");
  endtask

  initial begin
    rst_n = 1'b0;
    interval_cycles = 16'd0;
    timeout_cycles  = 16'(TO);
    step_size       = 11'(STEP);
    settle_band     = 9'd4;
    tau_band        = 11'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    run_cal("R4", 160, 104, 500);   // measured 80: gain halves, tau rises (R6)
    run_cal("R6", 120, 98, 300);    // measured 30: gain up, tau falls
    run_cal("R4", 1202, 98, 400);   // measured 400: rl saturates
    run_cal("R5", 0, 98, 400);      // zero measured step
    run_cal("R5", -603, 98, 400);   // negative measured step
    run_cal("R8", 1205, 200, 400);  // tau limited by iteration count
    t_base_timeout();
    t_step_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=150000 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule